// File: doc/BRIEF.md
# Host-Bound Mailbox Queue

This block is a word-wide queue that collects messages destined for a host processor and exposes them through a small register window. Producers place words at the tail through a push port. The host reads the head through a pop window, or through a peek register that leaves the queue unchanged. A status register reports the full and empty flags. A config register holds the has-data interrupt enable and a pending flag, and a level interrupt tells the host that words are waiting.

Storage is a shift chain. When the head is removed, every remaining word moves one slot toward the head, and the slot that becomes free is loaded with a reserved marker word. Reading the pop window while the queue is empty returns that marker and leaves all state as it was. Bus reads are combinational on the current state. Pops, pushes and config writes take effect at the next rising clock edge.

Top module: `hostq_mailbox`

## Requirements
- R1: After reset the queue is empty. Status reads with bit 30 = 1 and bit 31 = 0, config reads 0, `irq` is 0, and peek returns the marker (default 32'h0000_0001).
- R2: Words pushed through `push_valid`/`push_data` leave the pop window in the order they were pushed.
- R3: A bus read at any of the offsets 0x80, 0x84, 0x88 or 0x8C returns the head word and removes it from the queue.
- R4: A pop-window read while the queue is empty returns the marker and changes no state.
- R5: A read at offset 0x90 returns the head slot without removing it. Once the queue has been drained, that slot holds the marker.
- R6: At status offset 0x98, bit 31 is 1 exactly when the queue holds DEPTH words, bit 30 is 1 exactly when it holds none, and all other bits read 0.
- R7: A write to config offset 0x9C changes only bit 0, the has-data interrupt enable. On a read of 0x9C, bit 4 is 1 whenever the queue is not empty, and all other bits read 0.
- R8: `irq` is 1 exactly when the enable bit is set and the queue is not empty.
- R9: A push while the queue is full, with no pop in the same cycle, is dropped. `ovf_pulse` is then 1 for the one cycle after it.
- R10: When a push and a pop fall in the same cycle, the pop returns the old head and the pushed word is kept. This holds even when the queue is full, and in that case no overflow is flagged.
- R11: Only the low 8 bits of `bus_addr` are decoded. An unmapped offset reads as 0, and a write to any offset other than 0x9C has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; low 8 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is in progress |
| push_valid | input | 1 | Producer push request |
| push_data | input | 32 | Word to append |
| irq | output | 1 | Has-data interrupt, level |
| ovf_pulse | output | 1 | One-cycle flag for a dropped push |

## Verification
A host pop and a producer push can fall in the same cycle. The bench provokes this on a full queue and on an empty queue. On a full queue, the pop must return the old head, the new word must appear last in the drain order, and `ovf_pulse` must stay low. On an empty queue, the read must return the marker while the pushed word is still accepted, and a later peek must show that word.

// File: rtl/hostq_mailbox.sv
module hostq_mailbox #(
  parameter int DEPTH = 8,
  parameter int ADDR_W = 12,
  parameter logic [31:0] EMPTY_MARK = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              push_valid,
  input  logic [31:0]       push_data,
  output logic              irq,
  output logic              ovf_pulse
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [31:0]   slot [DEPTH];
  logic [CW-1:0] cnt;
  logic          irq_en;
  logic          ovf_q;

  wire [7:0] off       = bus_addr[7:0];
  wire       rd        = bus_valid & ~bus_write;
  wire       wr        = bus_valid & bus_write;
  wire       empty     = (cnt == '0);
  wire       full      = (cnt == FULL_CNT);
  wire       in_popwin = (off[7:4] == 4'h8) && (off[1:0] == 2'b00);
  wire       rd_pop    = rd & in_popwin & ~empty;
  wire       push_acc  = push_valid & (~full | rd_pop);
  wire [CW-1:0] cnt_after_pop = cnt - CW'(rd_pop);

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_slot
      logic [31:0] shifted;
      if (i == DEPTH - 1) begin : g_last
        assign shifted = rd_pop ? EMPTY_MARK : slot[i];
      end else begin : g_mid
        assign shifted = rd_pop ? slot[i+1] : slot[i];
      end
      always_ff @(posedge clk) begin
        if (!rst_n)
          slot[i] <= EMPTY_MARK;
        else if (push_acc && (cnt_after_pop == CW'(i)))
          slot[i] <= push_data;
        else
          slot[i] <= shifted;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      irq_en <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt   <= cnt_after_pop + CW'(push_acc);
      ovf_q <= push_valid & full & ~rd_pop;
      if (wr && off == 8'h9C)
        irq_en <= bus_wdata[0];
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (in_popwin)
      rd_val = empty ? EMPTY_MARK : slot[0];
    else begin
      case (off)
        8'h90:   rd_val = slot[0];
        8'h98:   rd_val = {full, empty, 30'b0};
        8'h9C:   rd_val = {27'b0, ~empty, 3'b0, irq_en};
        default: rd_val = '0;
      endcase
    end
  end

  assign bus_rdata = rd ? rd_val : '0;
  assign irq       = irq_en & ~empty;
  assign ovf_pulse = ovf_q;
endmodule

module hostq_mailbox_chk #(
  parameter int DEPTH = 8,
  parameter int CW = 4,
  parameter logic [31:0] EMPTY_MARK = 32'h0000_0001
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [7:0]    off,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          push_valid,
  input logic          irq,
  input logic          ovf_pulse,
  input logic [CW-1:0] cnt,
  input logic          irq_en
);
  wire popwin = bus_valid && !bus_write && off[7:4] == 4'h8 && off[1:0] == 2'b00;

  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popwin && cnt != 0 && !push_valid) |=> cnt == $past(cnt) - 1);

  // R4
  empty_pop_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popwin && cnt == 0) |-> bus_rdata == EMPTY_MARK);

  // R4
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popwin && cnt == 0 && !push_valid) |=> $stable(cnt));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && cnt == CW'(DEPTH) && !popwin) |=> (ovf_pulse && cnt == CW'(DEPTH)));

  // R7
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && off == 8'h9C) |=> irq_en == $past(bus_wdata[0]));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en || cnt == 0) |-> !irq);
endmodule

bind hostq_mailbox hostq_mailbox_chk #(
  .DEPTH(DEPTH), .CW(CW), .EMPTY_MARK(EMPTY_MARK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .off(bus_addr[7:0]), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .push_valid(push_valid), .irq(irq), .ovf_pulse(ovf_pulse),
  .cnt(cnt), .irq_en(irq_en)
);

// File: tb/hostq_mailbox_tb.sv
module hostq_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam logic [31:0] MARK = 32'h0000_0001;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        push_valid = 0;
  logic [31:0] push_data = 0;
  logic        irq, ovf_pulse;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostq_mailbox #(.DEPTH(DEPTH), .ADDR_W(12), .EMPTY_MARK(MARK)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .push_valid(push_valid), .push_data(push_data), .irq(irq), .ovf_pulse(ovf_pulse));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_valid = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = v;
    @(posedge clk); #1 bus_valid = 0; bus_write = 0;
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge clk);
    push_valid = 1; push_data = v;
    @(posedge clk); #1 push_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 irq", {31'b0, irq}, 0);
    rd(12'h098, d); chk("R1 status", d, 32'h4000_0000);
    rd(12'h09C, d); chk("R1 config", d, 0);
    rd(12'h090, d); chk("R1 peek", d, MARK);
  endtask

  task automatic t_order();
    logic [31:0] d;
    do_reset();
    push(32'hA0); push(32'hA1); push(32'hA2); push(32'hA3);
    rd(12'h090, d); chk("R5 peek head", d, 32'hA0);
    rd(12'h090, d); chk("R5 peek keeps", d, 32'hA0);
    rd(12'h080, d); chk("R3 pop 0x80", d, 32'hA0);
    rd(12'h084, d); chk("R2 order 0x84", d, 32'hA1);
    rd(12'h088, d); chk("R2 order 0x88", d, 32'hA2);
    rd(12'h08C, d); chk("R3 pop 0x8C", d, 32'hA3);
    rd(12'h090, d); chk("R5 vacated mark", d, MARK);
    rd(12'h098, d); chk("R6 empty again", d, 32'h4000_0000);
  endtask

  task automatic t_empty_pop();
    logic [31:0] d;
    do_reset();
    rd(12'h080, d); chk("R4 mark", d, MARK);
    rd(12'h098, d); chk("R4 still empty", d, 32'h4000_0000);
    push(32'h55);
    rd(12'h080, d); chk("R4 later pop", d, 32'h55);
  endtask

  task automatic t_full_ovf();
    logic [31:0] d;
    do_reset();
    for (int i = 0; i < DEPTH; i++) push(32'h100 + i);
    rd(12'h098, d); chk("R6 full", d, 32'h8000_0000);
    push(32'hDEAD);
    chk("R9 ovf pulse", {31'b0, ovf_pulse}, 1);
    @(posedge clk); #1 chk("R9 ovf single", {31'b0, ovf_pulse}, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(12'h080, d); chk("R9 drop kept order", d, 32'h100 + i);
    end
    rd(12'h080, d); chk("R9 dropped word absent", d, MARK);
  endtask

  task automatic t_concurrent();
    logic [31:0] d;
    do_reset();
    for (int i = 0; i < DEPTH; i++) push(32'h200 + i);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 12'h080;
    push_valid = 1; push_data = 32'hBEEF;
    #1 chk("R10 full pop old head", bus_rdata, 32'h200);
    @(posedge clk); #1 bus_valid = 0; push_valid = 0;
    chk("R10 no ovf", {31'b0, ovf_pulse}, 0);
    rd(12'h098, d); chk("R10 still full", d, 32'h8000_0000);
    for (int i = 1; i < DEPTH; i++) begin
      rd(12'h080, d); chk("R10 drain", d, 32'h200 + i);
    end
    rd(12'h080, d); chk("R10 pushed last", d, 32'hBEEF);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 12'h080;
    push_valid = 1; push_data = 32'hCAFE;
    #1 chk("R10 empty pop mark", bus_rdata, MARK);
    @(posedge clk); #1 bus_valid = 0; push_valid = 0;
    rd(12'h090, d); chk("R10 empty push kept", d, 32'hCAFE);
  endtask

  task automatic t_cfg_irq();
    logic [31:0] d;
    do_reset();
    wr(12'h09C, 32'hFFFF_FFFF);
    rd(12'h09C, d); chk("R7 only bit0", d, 32'h1);
    chk("R8 irq empty", {31'b0, irq}, 0);
    push(32'h77);
    chk("R8 irq set", {31'b0, irq}, 1);
    rd(12'h09C, d); chk("R7 pending", d, 32'h11);
    wr(12'h09C, 32'h0);
    chk("R8 irq disabled", {31'b0, irq}, 0);
    rd(12'h09C, d); chk("R7 pending w/o en", d, 32'h10);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    do_reset();
    push(32'h99);
    rd(12'h094, d); chk("R11 unmapped 0x94", d, 0);
    rd(12'h0A0, d); chk("R11 unmapped 0xA0", d, 0);
    rd(12'h090, d); chk("R11 unmapped read no pop", d, 32'h99);
    wr(12'h080, 32'h1234);
    wr(12'h098, 32'hFFFF_FFFF);
    rd(12'h09C, d); chk("R11 stray writes", d, 32'h10);
    wr(12'h39C, 32'h1);
    chk("R11 alias cfg", {31'b0, irq}, 1);
    rd(12'hF90, d); chk("R11 alias peek", d, 32'h99);
    rd(12'h580, d); chk("R11 alias pop", d, 32'h99);
    rd(12'h098, d); chk("R11 empty after alias", d, 32'h4000_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_empty_pop();
    t_full_ovf();
    t_concurrent();
    t_cfg_irq();
    t_decode();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule